// File: doc/BRIEF.md
# USB Host Port Suspend and Resume Control Register

This block is the suspend, resume and overcurrent-change part of one port's 32-bit status and control register in a USB 2.0 host controller. Software writes the whole register word. The block takes line events from the port logic: a detected J-to-K transition, high-speed idle reached, and suspend completed. It also takes an asynchronous overcurrent-active level. From these it keeps a small set of coupled bits, and it returns their readable value together with the port-enabled level it receives.

Suspend is requested by software. It shows as set only after the port logic reports that suspend is complete, and software cannot clear it. Resume is raised either by software or by a K state seen on a suspended port. Only the second case raises the controller-level port change pulse. Software ends the resume by writing the resume bit to zero. Hardware then drops suspend, stops driving K, and holds the resume bit at one until high-speed idle is reached. Overcurrent change records every edge of the synchronized overcurrent level and is cleared by writing a one to it.

Top module: `hostPortSuspendCtl`

## Requirements
- R1: After reset, with portEnabled low, regVal reads 00003000h. Bit 2 of regVal mirrors portEnabled. portState is 00 and suspendCmd, resumeDrive, downstreamBlock and portChangePulse are all low.
- R2: A write with bit 7 set while the port is enabled raises suspendCmd on the next cycle. Bit 7 stays 0 until suspendDone is seen. It then reads 1 on the following cycle, portState reads 11, and suspendCmd drops.
- R3: A write with bit 7 set while portEnabled is low does nothing. A write with bit 7 clear never clears a set suspend bit.
- R4: downstreamBlock is high exactly while suspend (bit 7) is set, except while portReset is high.
- R5: jToK while suspended sets bit 6 on the next cycle. On that same cycle portChangePulse is high, and it lasts exactly one cycle.
- R6: A software write with bit 6 set on an enabled port sets bit 6 and raises resumeDrive, and it never raises portChangePulse.
- R7: A write with bit 6 clear while bit 6 is 1 clears bit 7 and drops resumeDrive on the next cycle. Bit 6 keeps reading 1 until hsIdle is seen, and then it reads 0 on the following cycle.
- R8: Each rising or falling edge of ocActive sets bit 5 three cycles later. Writing 1 to bit 5 clears it, and writing 0 to bit 5 leaves it unchanged.
- R9: When an overcurrent edge and a clearing write to bit 5 fall on the same cycle, bit 5 ends up set.
- R10: When portEnabled drops, a pending suspend request and a set suspend bit are both cleared on the next cycle.
- R11: jToK while the port is not suspended leaves bit 6 and portChangePulse unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data, whole word |
| portEnabled | input | 1 | Port enabled level from port logic, read at bit 2 |
| portReset | input | 1 | Port reset in progress |
| jToK | input | 1 | J-to-K transition detected on the line |
| hsIdle | input | 1 | Port has reached high-speed idle |
| suspendDone | input | 1 | Port has completed entering suspend |
| ocActive | input | 1 | Asynchronous overcurrent-active level |
| regVal | output | 32 | Register read value |
| portState | output | 2 | {enabled, suspended} state pair |
| suspendCmd | output | 1 | Request to the port logic to enter suspend |
| resumeDrive | output | 1 | Drive full-speed K resume signaling |
| downstreamBlock | output | 1 | Block downstream data propagation |
| portChangePulse | output | 1 | One-cycle set of the controller port change status |

## Verification
The write strobes and line events go through one register stage, so their results are due one cycle later. An overcurrent edge goes through two synchronizer flops and one edge register, so its result is due three cycles later. The bench drives every input just after a falling edge and reads the outputs on the next falling edge, after exactly one rising edge. For the overcurrent cases it checks one cycle early, to see that the bit is still clear, and then again at the third cycle. The R9 case places a clearing write on the same rising edge that the overcurrent edge is registered.

// File: rtl/hpsPkg.sv
package hpsPkg;

  // Strobes from control to datapath, one cycle wide each
  typedef struct packed {
    logic reqSuspend;
    logic enterSuspend;
    logic dropSuspend;
    logic swResume;
    logic hwResume;
    logic beginExit;
    logic endResume;
    logic setOcc;
    logic clrOcc;
  } hpsStrobes_t;

  // {enabled, suspended}; any pair with enabled low is disabled
  typedef enum logic [1:0] {
    PS_DISABLED  = 2'b00,
    PS_DIS_ALT   = 2'b01,
    PS_ENABLED   = 2'b10,
    PS_SUSPENDED = 2'b11
  } portState_t;

endpackage

// File: rtl/hpsOcSync.sv
module hpsOcSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic levelOut,
  output logic edgeSeen
);
  logic [STAGES-1:0] chain;
  logic              lastLevel;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : gRest
        always_ff @(posedge clk) begin
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) lastLevel <= 1'b0;
    else       lastLevel <= chain[STAGES-1];
  end

  assign levelOut = chain[STAGES-1];
  assign edgeSeen = chain[STAGES-1] ^ lastLevel;
endmodule

// File: rtl/hpsControl.sv
module hpsControl
  import hpsPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SUSP_BIT    = 7,
  parameter int RES_BIT     = 6,
  parameter int OCC_BIT     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              portEnabled,
  input  logic              jToK,
  input  logic              hsIdle,
  input  logic              suspendDone,
  input  logic              ocActive,
  // state fed back from the datapath
  input  logic              suspReq,
  input  logic              suspended,
  input  logic              resume,
  input  logic              exiting,
  output hpsStrobes_t       strobes
);
  logic ocEdge;
  logic ocLevel;
  logic wrSusp;
  logic wrRes;
  logic wrOcc;

  hpsOcSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (ocActive),
    .levelOut(ocLevel),
    .edgeSeen(ocEdge)
  );

  assign wrSusp = wrEn & wrData[SUSP_BIT];
  assign wrRes  = wrEn & wrData[RES_BIT];
  assign wrOcc  = wrEn & wrData[OCC_BIT];

  always_comb begin
    strobes = '0;
    // a suspend request only counts on an enabled, idle, non-resuming port
    strobes.reqSuspend   = wrSusp & portEnabled & ~suspended & ~suspReq & ~resume;
    strobes.enterSuspend = suspReq & suspendDone & portEnabled;
    // a software resume wins over a line event in the same cycle: no change flag
    strobes.swResume     = wrRes & portEnabled & ~resume;
    strobes.hwResume     = suspended & jToK & portEnabled & ~resume & ~strobes.swResume;
    strobes.beginExit    = wrEn & ~wrData[RES_BIT] & resume & ~exiting;
    strobes.endResume    = exiting & hsIdle;
    strobes.dropSuspend  = strobes.beginExit | (~portEnabled & (suspended | suspReq));
    strobes.setOcc       = ocEdge;
    strobes.clrOcc       = wrOcc;
  end

  // R6
  sw_no_hw_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.swResume |-> !strobes.hwResume);

  // R11
  hw_needs_susp_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hwResume |-> suspended);

  // R8
  oc_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ocLevel != $past(ocLevel)) |-> strobes.setOcc);
endmodule

// File: rtl/hpsDatapath.sv
module hpsDatapath
  import hpsPkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              SUSP_BIT  = 7,
  parameter int              RES_BIT   = 6,
  parameter int              OCC_BIT   = 5,
  parameter int              EN_BIT    = 2,
  parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpsStrobes_t       strobes,
  input  logic              portEnabled,
  input  logic              portReset,
  output logic              suspReq,
  output logic              suspended,
  output logic              resume,
  output logic              exiting,
  output logic              occ,
  output logic              changePulse,
  output logic [DATA_W-1:0] regVal,
  output logic              resumeDrive,
  output logic              downstreamBlock
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      suspReq     <= 1'b0;
      suspended   <= 1'b0;
      resume      <= 1'b0;
      exiting     <= 1'b0;
      occ         <= 1'b0;
      changePulse <= 1'b0;
    end else begin
      if (strobes.dropSuspend || strobes.enterSuspend) suspReq <= 1'b0;
      else if (strobes.reqSuspend)                     suspReq <= 1'b1;

      if (strobes.dropSuspend)       suspended <= 1'b0;
      else if (strobes.enterSuspend) suspended <= 1'b1;

      if (strobes.endResume)                           resume <= 1'b0;
      else if (strobes.swResume || strobes.hwResume)   resume <= 1'b1;

      if (strobes.endResume)      exiting <= 1'b0;
      else if (strobes.beginExit) exiting <= 1'b1;

      // hardware set outranks the software clear
      if (strobes.setOcc)      occ <= 1'b1;
      else if (strobes.clrOcc) occ <= 1'b0;

      changePulse <= strobes.hwResume;
    end
  end

  always_comb begin
    regVal           = RESET_VAL;
    regVal[EN_BIT]   = portEnabled;
    regVal[SUSP_BIT] = suspended;
    regVal[RES_BIT]  = resume;
    regVal[OCC_BIT]  = occ;
  end

  assign resumeDrive     = resume & ~exiting;
  assign downstreamBlock = suspended & ~portReset;

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    changePulse |=> !changePulse);

  // R5
  pulse_with_res_chk: assert property (@(posedge clk) disable iff (!rstN)
    changePulse |-> resume);

  // R7
  exit_holds_res_chk: assert property (@(posedge clk) disable iff (!rstN)
    exiting |-> resume);

  // R7
  res_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resume) |-> $past(exiting));

  // R9
  occ_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setOcc |=> occ);

  // R3
  susp_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspended) |-> $past(portEnabled) && $past(suspReq));
endmodule

// File: rtl/hostPortSuspendCtl.sv
module hostPortSuspendCtl
  import hpsPkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                SUSP_BIT    = 7,
  parameter int                RES_BIT     = 6,
  parameter int                OCC_BIT     = 5,
  parameter int                EN_BIT      = 2,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] RESET_VAL   = 32'h0000_3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              portEnabled,
  input  logic              portReset,
  input  logic              jToK,
  input  logic              hsIdle,
  input  logic              suspendDone,
  input  logic              ocActive,
  output logic [DATA_W-1:0] regVal,
  output logic [1:0]        portState,
  output logic              suspendCmd,
  output logic              resumeDrive,
  output logic              downstreamBlock,
  output logic              portChangePulse
);
  hpsStrobes_t strobes;
  logic suspReq, suspended, resume, exiting, occ, changePulse;
  portState_t stateNow;

  hpsControl #(
    .DATA_W(DATA_W), .SUSP_BIT(SUSP_BIT), .RES_BIT(RES_BIT),
    .OCC_BIT(OCC_BIT), .SYNC_STAGES(SYNC_STAGES)
  ) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .portEnabled(portEnabled), .jToK(jToK), .hsIdle(hsIdle),
    .suspendDone(suspendDone), .ocActive(ocActive),
    .suspReq(suspReq), .suspended(suspended), .resume(resume),
    .exiting(exiting), .strobes(strobes)
  );

  hpsDatapath #(
    .DATA_W(DATA_W), .SUSP_BIT(SUSP_BIT), .RES_BIT(RES_BIT),
    .OCC_BIT(OCC_BIT), .EN_BIT(EN_BIT), .RESET_VAL(RESET_VAL)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .portEnabled(portEnabled), .portReset(portReset),
    .suspReq(suspReq), .suspended(suspended), .resume(resume),
    .exiting(exiting), .occ(occ), .changePulse(changePulse),
    .regVal(regVal), .resumeDrive(resumeDrive),
    .downstreamBlock(downstreamBlock)
  );

  assign stateNow        = portState_t'({portEnabled, suspended});
  assign portState       = stateNow;
  assign suspendCmd      = suspReq;
  assign portChangePulse = changePulse;

  // R4
  block_only_susp_chk: assert property (@(posedge clk) disable iff (!rstN)
    downstreamBlock |-> regVal[SUSP_BIT] && !portReset);

  // R10
  disable_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    !portEnabled |=> !suspendCmd);
endmodule

// File: tb/sim_hostPortSuspendCtl.sv
module sim_hostPortSuspendCtl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [31:0] wrData;
  logic        portEnabled, portReset, jToK, hsIdle, suspendDone, ocActive;
  logic [31:0] regVal;
  logic [1:0]  portState;
  logic        suspendCmd, resumeDrive, downstreamBlock, portChangePulse;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostPortSuspendCtl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .portEnabled(portEnabled), .portReset(portReset), .jToK(jToK),
    .hsIdle(hsIdle), .suspendDone(suspendDone), .ocActive(ocActive),
    .regVal(regVal), .portState(portState), .suspendCmd(suspendCmd),
    .resumeDrive(resumeDrive), .downstreamBlock(downstreamBlock),
    .portChangePulse(portChangePulse)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; portEnabled = 1'b0; portReset = 1'b0;
    jToK = 1'b0; hsIdle = 1'b0; suspendDone = 1'b0; ocActive = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
  endtask

  // drive port into suspended state (enabled)
  task automatic goSuspend();
    portEnabled = 1'b1;
    wr(32'h80);
    suspendDone = 1'b1; tick(); suspendDone = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    chk("R1", "regVal", regVal, 32'h0000_3000);
    chk("R1", "portState", {30'b0, portState}, 32'h0);
    chk("R1", "outs", {28'b0, suspendCmd, resumeDrive, downstreamBlock, portChangePulse}, 32'h0);
    portEnabled = 1'b1; tick();
    chk("R1", "enabled bit2", regVal, 32'h0000_3004);
  endtask

  task automatic testSuspendEntry();
    doReset();
    portEnabled = 1'b1;
    wr(32'h80);
    chk("R2", "suspendCmd", {31'b0, suspendCmd}, 32'h1);
    chk("R2", "bit7 before done", {31'b0, regVal[7]}, 32'h0);
    tick();
    chk("R2", "bit7 waits", {31'b0, regVal[7]}, 32'h0);
    suspendDone = 1'b1; tick(); suspendDone = 1'b0;
    chk("R2", "bit7 set", {31'b0, regVal[7]}, 32'h1);
    chk("R2", "state 11", {30'b0, portState}, 32'h3);
    chk("R2", "suspendCmd drops", {31'b0, suspendCmd}, 32'h0);
    chk("R4", "block", {31'b0, downstreamBlock}, 32'h1);
    portReset = 1'b1; #1;
    chk("R4", "block during reset", {31'b0, downstreamBlock}, 32'h0);
    portReset = 1'b0; #1;
    wr(32'h0);
    chk("R3", "write0 keeps bit7", {31'b0, regVal[7]}, 32'h1);
  endtask

  task automatic testSuspendDisabled();
    doReset();
    wr(32'h80);
    chk("R3", "no cmd when disabled", {31'b0, suspendCmd}, 32'h0);
    suspendDone = 1'b1; tick(); suspendDone = 1'b0;
    chk("R3", "bit7 stays 0", {31'b0, regVal[7]}, 32'h0);
  endtask

  task automatic testHwResume();
    doReset();
    jToK = 1'b1; portEnabled = 1'b1; tick(); jToK = 1'b0;
    chk("R11", "no resume when not suspended", {31'b0, regVal[6]}, 32'h0);
    chk("R11", "no pulse", {31'b0, portChangePulse}, 32'h0);
    goSuspend();
    jToK = 1'b1; tick(); jToK = 1'b0;
    chk("R5", "bit6 set", {31'b0, regVal[6]}, 32'h1);
    chk("R5", "pulse", {31'b0, portChangePulse}, 32'h1);
    chk("R5", "K driven", {31'b0, resumeDrive}, 32'h1);
    tick();
    chk("R5", "pulse one cycle", {31'b0, portChangePulse}, 32'h0);
    // end resume: write bit6=0
    wr(32'h0);
    chk("R7", "suspend cleared", {31'b0, regVal[7]}, 32'h0);
    chk("R7", "bit6 held", {31'b0, regVal[6]}, 32'h1);
    chk("R7", "K stops", {31'b0, resumeDrive}, 32'h0);
    tick();
    chk("R7", "bit6 still held", {31'b0, regVal[6]}, 32'h1);
    hsIdle = 1'b1; tick(); hsIdle = 1'b0;
    chk("R7", "bit6 clears at idle", {31'b0, regVal[6]}, 32'h0);
  endtask

  task automatic testSwResume();
    bit sawPulse;
    doReset();
    goSuspend();
    sawPulse = 0;
    wrEn = 1'b1; wrData = 32'h40;
    tick(); sawPulse |= portChangePulse;
    wrEn = 1'b0; wrData = '0;
    chk("R6", "bit6 set", {31'b0, regVal[6]}, 32'h1);
    chk("R6", "K driven", {31'b0, resumeDrive}, 32'h1);
    jToK = 1'b1; tick(); sawPulse |= portChangePulse; jToK = 1'b0;
    tick(); sawPulse |= portChangePulse;
    chk("R6", "no change pulse", {31'b0, sawPulse}, 32'h0);
  endtask

  task automatic testOc();
    doReset();
    ocActive = 1'b1;
    tick(); tick();
    chk("R8", "not yet set", {31'b0, regVal[5]}, 32'h0);
    tick();
    chk("R8", "set on rise", {31'b0, regVal[5]}, 32'h1);
    wr(32'h0);
    chk("R8", "write0 keeps", {31'b0, regVal[5]}, 32'h1);
    wr(32'h20);
    chk("R8", "w1c clears", {31'b0, regVal[5]}, 32'h0);
    ocActive = 1'b0;
    tick(); tick();
    chk("R8", "fall not yet", {31'b0, regVal[5]}, 32'h0);
    tick();
    chk("R8", "set on fall", {31'b0, regVal[5]}, 32'h1);
    wr(32'h20);
    chk("R8", "cleared again", {31'b0, regVal[5]}, 32'h0);
    ocActive = 1'b1;
    tick(); tick();
    wr(32'h20);
    chk("R9", "set beats clear", {31'b0, regVal[5]}, 32'h1);
  endtask

  task automatic testDisable();
    doReset();
    goSuspend();
    portEnabled = 1'b0; tick();
    chk("R10", "suspend dropped", {31'b0, regVal[7]}, 32'h0);
    chk("R10", "block low", {31'b0, downstreamBlock}, 32'h0);
    portEnabled = 1'b1;
    wr(32'h80);
    portEnabled = 1'b0; tick();
    chk("R10", "request dropped", {31'b0, suspendCmd}, 32'h0);
  endtask

  initial begin
    fork
      begin
        testReset();
        testSuspendEntry();
        testSuspendDisabled();
        testHwResume();
        testSwResume();
        testOc();
        testDisable();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule